// File: doc/BRIEF.md
# Variable-Length Extent Boundary Decoder

This block sits in an instruction fetch path that handles free-format code blocks. In such a block, the region after the header holds fourteen 16-bit extents. Instructions in that region may be 1 to 6 extents long, and an instruction may run past the end of the block into the next one. The header supplies two fields. A 4-bit count gives how many extents hold instruction code. A 15-bit mark field records every instruction boundary: bit k set means a new instruction starts at extent k. Read one position lower, the same bit means the instruction in extent k-1 ends there. So the field acts as a start map over bits 0..13 and as an end map over bits 1..14 at the same time.

From these two fields, the entry mode (reached by a branch or by falling through) and the number of extents an unfinished instruction already used in the previous block, the decoder produces:
- per-extent start and end masks;
- the length of every instruction that completes;
- the completed length of the instruction carried in from the previous block;
- an incomplete flag with the partial length of an instruction that runs off the end;
- three error flags.

Every result is registered and appears one cycle after the request. Decoding the contents of the instructions is left to later stages.

Top module: `exb_extent_decoder`

## Requirements
- R1: The decodable count N is the count field when it is below 14, and 14 when it is 14 or 15. `start_mask` bit i equals mark bit i for i < N and is 0 for every other i.
- R2: On fall-through entry, `end_mask` bit i equals mark bit i+1 for i < N and is 0 for every other i.
- R3: `err_end_past` is 1 exactly when some mark bit at a position from N+1 to 14 is 1.
- R4: For each start extent i, the field `len_bus[5*i +: 5]` holds j-i. Here j is the lowest index above i, with j ≤ N, whose mark bit is 1. Fields of extents that are not starts, or that have no such j, hold 0.
- R5: When the last start extent q has no mark bit set in positions q+1..N, `incomplete` is 1 and `partial_len` is N-q.
- R6: On branch entry (`via_branch`=1), the carry-in is ignored. The end marks of the extents before the first start are cleared, and all end marks are cleared when there is no start.
- R7: On fall-through entry with carry-in c > 0, let p be the lowest index ≤ N whose mark bit is 1. If p ≥ 1, `head_len` is c+p. If there is no such index, `incomplete` is 1, `partial_len` is c+N and `head_len` is 0.
- R8: `err_len` is 1 when any completed length in `len_bus` or `head_len` exceeds 6, or when an incomplete instruction already has a partial length of 6 or more.
- R9: `err_consist` is 1 in two cases on fall-through entry: the carry-in is 0, N > 0 and mark bit 0 is 0; or the carry-in is nonzero and mark bit 0 is 1. While it is set, `len_bus`, `head_len` and `partial_len` are 0.
- R10: `out_valid` rises one cycle after each accepted `in_valid` and is 0 in the cycle after an idle one. During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| dec_cnt | input | 4 | Decodable extent count (15 means all) |
| mark_field | input | 15 | Shared start/end boundary field |
| via_branch | input | 1 | Block entered by a branch |
| carry_in | input | 3 | Extents of an unfinished instruction already seen in the previous block |
| out_valid | output | 1 | Results valid |
| start_mask | output | 14 | Extents that begin an instruction |
| end_mask | output | 14 | Extents that end an instruction |
| len_bus | output | 70 | Per-extent completed length, 5 bits per extent |
| head_len | output | 5 | Completed length of the carried-in instruction |
| incomplete | output | 1 | Last instruction continues into the next block |
| partial_len | output | 5 | Extents of that instruction seen so far |
| err_end_past | output | 1 | End mark beyond the decodable region |
| err_len | output | 1 | Illegal instruction length |
| err_consist | output | 1 | Boundary marks inconsistent with the entry state |

## Verification
Some properties are checked on every cycle. The valid timing is one of them. Others tie outputs together: lengths are forced to zero under a consistency error, a reported partial length is never zero, and a long partial length always comes with a length error. Both masks are also checked never to hold more set bits than the decodable count. Only the bench's sweeps can show that the actual boundary positions and lengths match the mark field. The same holds for the interplay of carry-in, branch suppression and the decodable count. The bench compares every output against an arithmetic model over all counts, both entry modes and all carry-in values, and it sweeps every mark pattern at full count.

// File: rtl/exb_pkg.sv
package exb_pkg;

   // How the block was entered, as seen by the leading-extent logic.
   typedef enum logic [1:0] {
      ENTRY_BRANCH = 2'd0,
      ENTRY_FRESH  = 2'd1,
      ENTRY_CARRY  = 2'd2
   } entry_e;

   function automatic entry_e classify_entry(input logic branch, input logic carry_nz);
      if (branch)        return ENTRY_BRANCH;
      else if (carry_nz) return ENTRY_CARRY;
      else               return ENTRY_FRESH;
   endfunction

endpackage

// File: rtl/exb_window.sv
module exb_window #(
   parameter int EXT = 14,
   parameter int DW  = 4,
   parameter int LW  = 5
) (
   input  logic [DW-1:0] dec,
   output logic [EXT-1:0] live,
   output logic [EXT:0]   reach,
   output logic [LW-1:0]  n_ext
);
   localparam int ALL = (2**DW) - 1;

   initial begin
      assert (EXT < 2**DW) else $error("exb_window: count field too narrow for EXT");
      assert (2**LW > EXT) else $error("exb_window: LW too narrow for EXT");
   end

   always_comb begin
      if (int'(dec) == ALL || int'(dec) >= EXT) n_ext = LW'(EXT);
      else                                      n_ext = LW'(dec);
   end

   // live: extent lies inside the decodable region; reach: boundary position may be read
   for (genvar i = 0; i < EXT; i++) begin : g_live
      assign live[i] = (LW'(i) < n_ext);
   end
   for (genvar i = 0; i <= EXT; i++) begin : g_reach
      assign reach[i] = (LW'(i) <= n_ext);
   end
endmodule

// File: rtl/exb_scan.sv
module exb_scan #(
   parameter int EXT  = 14,
   parameter int LW   = 5,
   parameter int MAXL = 6
) (
   input  logic [EXT:0]      field,
   input  logic [EXT-1:0]    live,
   input  logic [EXT:0]      reach,
   input  logic [LW-1:0]     n_ext,
   output logic [EXT*LW-1:0] len_bus,
   output logic              open_flag,
   output logic [LW-1:0]     open_len,
   output logic              long_err,
   output logic [LW-1:0]     first_start,
   output logic [LW-1:0]     first_bnd,
   output logic              bnd_found
);
   initial begin
      assert (MAXL >= 1 && MAXL <= EXT) else $error("exb_scan: MAXL out of range");
   end

   // Walk from the top so each start sees the nearest boundary above it.
   always_comb begin
      int nxt;
      nxt       = -1;
      len_bus   = '0;
      open_flag = 1'b0;
      open_len  = '0;
      long_err  = 1'b0;
      for (int k = EXT; k >= 0; k--) begin
         if (k < EXT) begin
            if (field[k] && live[k]) begin
               if (nxt < 0) begin
                  open_flag = 1'b1;
                  open_len  = n_ext - LW'(k);
                  if (open_len >= LW'(MAXL)) long_err = 1'b1;
               end else begin
                  len_bus[k*LW +: LW] = LW'(nxt - k);
                  if ((nxt - k) > MAXL) long_err = 1'b1;
               end
            end
         end
         if (field[k] && reach[k]) nxt = k;
      end
   end

   always_comb begin
      logic hit;
      hit         = 1'b0;
      first_start = n_ext;
      for (int k = 0; k < EXT; k++) begin
         if (!hit && field[k] && live[k]) begin
            first_start = LW'(k);
            hit         = 1'b1;
         end
      end
   end

   always_comb begin
      bnd_found = 1'b0;
      first_bnd = '0;
      for (int k = 0; k <= EXT; k++) begin
         if (!bnd_found && field[k] && reach[k]) begin
            first_bnd = LW'(k);
            bnd_found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/exb_lead.sv
module exb_lead
   import exb_pkg::*;
#(
   parameter int LW   = 5,
   parameter int CW   = 3,
   parameter int MAXL = 6
) (
   input  logic [CW-1:0] carry,
   input  logic          branch,
   input  logic [LW-1:0] n_ext,
   input  logic          mark0,
   input  logic [LW-1:0] first_bnd,
   input  logic          bnd_found,
   output logic [LW-1:0] head_len,
   output logic          head_open,
   output logic [LW-1:0] head_partial,
   output logic          head_long,
   output logic          consist_err
);
   entry_e mode;

   initial begin
      assert (2**LW > 2**CW) else $error("exb_lead: LW too narrow for carry sums");
   end

   assign mode = classify_entry(branch, carry != '0);

   always_comb begin
      head_len     = '0;
      head_open    = 1'b0;
      head_partial = '0;
      head_long    = 1'b0;
      consist_err  = 1'b0;
      case (mode)
         ENTRY_CARRY: begin
            if (bnd_found) begin
               if (first_bnd == '0) consist_err = 1'b1;
               else begin
                  head_len  = LW'(carry) + first_bnd;
                  head_long = (head_len > LW'(MAXL));
               end
            end else begin
               head_open    = 1'b1;
               head_partial = LW'(carry) + n_ext;
               head_long    = (head_partial >= LW'(MAXL));
            end
         end
         ENTRY_FRESH: begin
            if (n_ext != '0 && !mark0) consist_err = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/exb_extent_decoder.sv
module exb_extent_decoder #(
   parameter int EXT  = 14,
   parameter int DW   = 4,
   parameter int CW   = 3,
   parameter int MAXL = 6,
   localparam int LW  = $clog2((2**CW) + EXT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DW-1:0]     dec_cnt,
   input  logic [EXT:0]      mark_field,
   input  logic              via_branch,
   input  logic [CW-1:0]     carry_in,
   output logic              out_valid,
   output logic [EXT-1:0]    start_mask,
   output logic [EXT-1:0]    end_mask,
   output logic [EXT*LW-1:0] len_bus,
   output logic [LW-1:0]     head_len,
   output logic              incomplete,
   output logic [LW-1:0]     partial_len,
   output logic              err_end_past,
   output logic              err_len,
   output logic              err_consist
);
   logic [EXT-1:0]    live;
   logic [EXT:0]      reach;
   logic [LW-1:0]     n_ext;
   logic [EXT*LW-1:0] s_len;
   logic              s_open, s_long, bnd_found;
   logic [LW-1:0]     s_open_len, first_start, first_bnd;
   logic [LW-1:0]     h_len, h_partial;
   logic              h_open, h_long, h_consist;
   logic [EXT-1:0]    c_start, c_end, c_past;

   exb_window #(.EXT(EXT), .DW(DW), .LW(LW)) u_win (
      .dec(dec_cnt), .live(live), .reach(reach), .n_ext(n_ext)
   );

   exb_scan #(.EXT(EXT), .LW(LW), .MAXL(MAXL)) u_scan (
      .field(mark_field), .live(live), .reach(reach), .n_ext(n_ext),
      .len_bus(s_len), .open_flag(s_open), .open_len(s_open_len), .long_err(s_long),
      .first_start(first_start), .first_bnd(first_bnd), .bnd_found(bnd_found)
   );

   exb_lead #(.LW(LW), .CW(CW), .MAXL(MAXL)) u_lead (
      .carry(carry_in), .branch(via_branch), .n_ext(n_ext), .mark0(mark_field[0]),
      .first_bnd(first_bnd), .bnd_found(bnd_found),
      .head_len(h_len), .head_open(h_open), .head_partial(h_partial),
      .head_long(h_long), .consist_err(h_consist)
   );

   for (genvar i = 0; i < EXT; i++) begin : g_mask
      assign c_start[i] = mark_field[i] & live[i];
      assign c_end[i]   = mark_field[i+1] & live[i] & ~(via_branch & (LW'(i) < first_start));
      assign c_past[i]  = mark_field[i+1] & ~live[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         start_mask   <= '0;
         end_mask     <= '0;
         len_bus      <= '0;
         head_len     <= '0;
         incomplete   <= 1'b0;
         partial_len  <= '0;
         err_end_past <= 1'b0;
         err_len      <= 1'b0;
         err_consist  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            start_mask   <= c_start;
            end_mask     <= c_end;
            incomplete   <= s_open | h_open;
            err_end_past <= |c_past;
            err_len      <= s_long | h_long;
            err_consist  <= h_consist;
            if (h_consist) begin
               len_bus     <= '0;
               head_len    <= '0;
               partial_len <= '0;
            end else begin
               len_bus     <= s_len;
               head_len    <= h_len;
               partial_len <= s_open ? s_open_len : (h_open ? h_partial : '0);
            end
         end
      end
   end

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r9_lengths_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && err_consist) |-> (len_bus == '0 && head_len == '0 && partial_len == '0));
   a_r5_partial_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && incomplete && !err_consist) |-> (partial_len != '0));
   a_r8_long_open_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && incomplete && partial_len >= LW'(MAXL)) |-> err_len);
   a_r1_start_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ($countones(start_mask) <= int'($past(n_ext))));
   a_r2_end_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ($countones(end_mask) <= int'($past(n_ext))));
endmodule

// File: tb/exb_extent_decoder_tb.sv
module exb_extent_decoder_tb;
   localparam int EXT = 14;
   localparam int LW  = 5;
   localparam int MAXL = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid;
   logic [3:0]        dec_cnt;
   logic [EXT:0]      mark_field;
   logic              via_branch;
   logic [2:0]        carry_in;
   logic              out_valid;
   logic [EXT-1:0]    start_mask, end_mask;
   logic [EXT*LW-1:0] len_bus;
   logic [LW-1:0]     head_len, partial_len;
   logic              incomplete, err_end_past, err_len, err_consist;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [31:0] rng = 32'h1234_5678;

   logic [EXT-1:0]    x_start, x_end;
   logic [EXT*LW-1:0] x_len;
   logic [LW-1:0]     x_head, x_part;
   logic              x_inc, x_past, x_long, x_cons;

   always #5 clk = ~clk;

   exb_extent_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec_cnt(dec_cnt),
      .mark_field(mark_field), .via_branch(via_branch), .carry_in(carry_in),
      .out_valid(out_valid), .start_mask(start_mask), .end_mask(end_mask),
      .len_bus(len_bus), .head_len(head_len), .incomplete(incomplete),
      .partial_len(partial_len), .err_end_past(err_end_past), .err_len(err_len),
      .err_consist(err_consist)
   );

   task automatic summary_and_end();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000) begin
         $display("FAIL watchdog: run did not complete, actual %0d cycles expected < 190000", cycles);
         errors = errors + 1;
         summary_and_end();
      end
   end

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] nxt_rng(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   // Arithmetic model built from the requirements.
   task automatic model(input int d, input logic [EXT:0] f, input logic br, input int c);
      int n, pst, q, j, len, first;
      logic found;
      n = (d >= EXT) ? EXT : d;
      x_start = '0; x_end = '0; x_len = '0; x_head = '0; x_part = '0;
      x_inc = 0; x_past = 0; x_long = 0; x_cons = 0;
      pst = n;
      for (int i = n - 1; i >= 0; i--) if (f[i]) pst = i;
      for (int i = 0; i < EXT; i++) begin
         if (i < n) begin
            x_start[i] = f[i];
            x_end[i]   = f[i+1] && !(br && i < pst);
         end else if (f[i+1]) x_past = 1;
      end
      for (int i = 0; i < n; i++) begin
         if (f[i]) begin
            j = i + 1;
            while (j <= n && !f[j]) j++;
            if (j <= n) begin
               len = j - i;
               x_len[i*LW +: LW] = LW'(len);
               if (len > MAXL) x_long = 1;
            end else begin
               x_inc = 1; x_part = LW'(n - i);
               if (n - i >= MAXL) x_long = 1;
            end
         end
      end
      if (!br && c > 0) begin
         first = 0; found = 0;
         while (first <= n && !found) begin
            if (f[first]) found = 1; else first++;
         end
         if (found && first == 0) x_cons = 1;
         else if (found) begin
            x_head = LW'(c + first);
            if (c + first > MAXL) x_long = 1;
         end else begin
            x_inc = 1; x_part = LW'(c + n);
            if (c + n >= MAXL) x_long = 1;
         end
      end else if (!br && n > 0 && !f[0]) x_cons = 1;
      if (x_cons) begin x_len = '0; x_head = '0; x_part = '0; end
   endtask

   task automatic drive(input int d, input logic [EXT:0] f, input logic br, input int c);
      dec_cnt = 4'(d); mark_field = f; via_branch = br; carry_in = 3'(c); in_valid = 1'b1;
      @(negedge clk);
   endtask

   task automatic compare_all(input logic br);
      chk(out_valid == 1'b1, "R10", "out_valid", 128'(out_valid), 128'(1));
      chk(start_mask == x_start, "R1", "start_mask", 128'(start_mask), 128'(x_start));
      chk(end_mask == x_end, br ? "R6" : "R2", "end_mask", 128'(end_mask), 128'(x_end));
      chk(err_end_past == x_past, "R3", "err_end_past", 128'(err_end_past), 128'(x_past));
      chk(len_bus == x_len, "R4", "len_bus", 128'(len_bus), 128'(x_len));
      chk(incomplete == x_inc && partial_len == x_part, "R5", "incomplete/partial",
          {incomplete, 3'b0, partial_len}, {x_inc, 3'b0, x_part});
      chk(head_len == x_head, "R7", "head_len", 128'(head_len), 128'(x_head));
      chk(err_len == x_long, "R8", "err_len", 128'(err_len), 128'(x_long));
      chk(err_consist == x_cons, "R9", "err_consist", 128'(err_consist), 128'(x_cons));
   endtask

   task automatic run_vec(input int d, input logic [EXT:0] f, input logic br, input int c);
      model(d, f, br, c);
      drive(d, f, br, c);
      compare_all(br);
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; dec_cnt = '0; mark_field = '0;
      via_branch = 1'b0; carry_in = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(out_valid == 0 && start_mask == 0 && end_mask == 0 && len_bus == 0 &&
          incomplete == 0 && err_len == 0 && err_consist == 0 && err_end_past == 0,
          "R10", "reset outputs", 128'(out_valid), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R6 directed: branch entry, starts at 3 and 9, end at 14
      drive(15, 15'(1 << 3 | 1 << 9 | 1 << 14), 1'b1, 5);
      chk(start_mask == 14'h0208, "R6", "branch start_mask", 128'(start_mask), 128'h0208);
      chk(end_mask == 14'h2100, "R6", "branch end_mask", 128'(end_mask), 128'h2100);
      chk(len_bus[3*LW +: LW] == 5'd6 && len_bus[9*LW +: LW] == 5'd5, "R4", "branch lengths",
          128'(len_bus), 128'(0));
      chk(head_len == 0 && err_consist == 0 && err_len == 0, "R6", "carry ignored",
          {err_consist, err_len, 3'b0, head_len}, 128'(0));

      // R7 directed: carry 2, N=5, boundary at 3 -> head 5, open start at 3 partial 2
      drive(5, 15'(1 << 3), 1'b0, 2);
      chk(head_len == 5'd5, "R7", "head_len", 128'(head_len), 128'd5);
      chk(incomplete == 1 && partial_len == 5'd2, "R5", "open partial",
          {incomplete, 3'b0, partial_len}, {1'b1, 3'b0, 5'd2});

      // R10 idle cycle
      in_valid = 1'b0;
      @(negedge clk);
      chk(out_valid == 0, "R10", "idle out_valid", 128'(out_valid), 128'(0));

      // Exhaustive mark sweep at full count, fresh fall-through
      for (int f = 0; f < 32768; f++) run_vec(15, 15'(f), 1'b0, 0);

      // Pseudo-random sweep over every count, entry mode and carry value
      for (int d = 0; d < 16; d++) begin
         for (int b = 0; b < 2; b++) begin
            for (int c = 0; c < 8; c++) begin
               for (int r = 0; r < 110; r++) begin
                  rng = nxt_rng(rng);
                  run_vec(d, rng[14:0], b[0], c);
               end
            end
         end
      end

      in_valid = 1'b0;
      @(negedge clk);
      summary_and_end();
   end
endmodule